// File: doc/BRIEF.md
# SPI FIFO Status Flag Unit

This unit keeps the status and request flags of a queued SPI controller that has a transmit FIFO and a receive FIFO. The FIFOs, the shift engine and a DMA handshake reach it only as single-cycle strobes and level inputs. From these it keeps five flags and a transmit entry counter, and presents them as one 32-bit status word. A flag is cleared by writing one to its bit in that word. The unit also keeps a transfer-running bit, which leaves the status word as a separate output.

The end-of-queue flag, the underflow flag and the overflow flag are sticky flags. Each is set by one event. The fill flag and the drain flag follow a FIFO level, but they keep their value once the level has gone away, until software or the DMA acknowledge clears them. Two registered request outputs, each gated by its own enable, ask for the transmit FIFO to be filled and for the receive FIFO to be drained.

The reset input is active low and asynchronous. Its release is synchronised inside the unit with two flops, so the state stays cleared for two rising clock edges after `rst_n` goes high.

Top module: `spi_stat_flags`

## Requirements
Bit positions are the index of the `status` vector, where index 31 is the most significant bit. The end-of-queue flag is at index 28 and the underflow flag at 27. The fill flag is at 25, the overflow flag at 19 and the drain flag at 17. The TX counter is at 15:12, with its MSB at 15. Every other bit reads zero. Unless stated otherwise, a change caused by the inputs of one cycle appears after the next rising edge.

- R1: The end-of-queue flag (index 28) sets when `eoq_done` is high and `slave_mode` is low. It never sets while `slave_mode` is high.
- R2: `running` sets on `run_go` and clears on `run_halt`. An end-of-queue set event (as in R1) clears it, and this takes priority over `run_go`.
- R3: The underflow flag (index 27) sets when `xfer_start`, `slave_mode` and `tx_empty` are all high. It never sets while `slave_mode` is low.
- R4: The overflow flag (index 19) sets when `xfer_start`, `rx_full` and `rx_shift_full` are all high.
- R5: The fill flag (index 25) sets in every cycle in which `tx_full` is low. Once set, it stays set after `tx_full` rises. It is cleared by a write of one to index 25, or by `dma_tx_ack` while `tx_full` is high.
- R6: The drain flag (index 17) sets in every cycle in which `rx_empty` is low. Once set, it stays set after `rx_empty` rises. It is cleared by a write of one to index 17, or by `dma_rx_ack` while `rx_empty` is high.
- R7: A write (`wr_en` high) clears each flag whose bit in `wr_data` is one. It leaves flags written with zero unchanged. When a flag's set condition and a clear happen in the same cycle, the set wins.
- R8: The TX counter (index 15:12) rises by one on `tx_push` and falls by one on `tx_pop`. It holds its value when both arrive in the same cycle. It stays at 15 on a push alone and stays at 0 on a pop alone.
- R9: `fill_req` equals the fill flag ANDed with `fill_req_en`, and `drain_req` equals the drain flag ANDed with `drain_req_en`. Each is registered, so it follows the flag and the enable of the previous cycle.
- R10: All status bits other than the listed fields read zero.
- R11: While reset is held, and for two edges after it is released, `status`, `running`, `fill_req` and `drain_req` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | High when the controller acts as SPI slave |
| run_go | input | 1 | Strobe: start transfers |
| run_halt | input | 1 | Strobe: stop transfers |
| eoq_done | input | 1 | Strobe: last bit of an end-of-queue command sampled |
| xfer_start | input | 1 | Strobe: a serial transfer begins |
| tx_push | input | 1 | Strobe: an entry is written into the TX FIFO |
| tx_pop | input | 1 | Strobe: a command moves into the shift register |
| tx_full | input | 1 | TX FIFO full level |
| tx_empty | input | 1 | TX FIFO empty level |
| rx_full | input | 1 | RX FIFO full level |
| rx_shift_full | input | 1 | Receive shift register holds unread data |
| rx_empty | input | 1 | RX FIFO empty level |
| dma_tx_ack | input | 1 | DMA acknowledge for the fill request |
| dma_rx_ack | input | 1 | DMA acknowledge for the drain request |
| wr_en | input | 1 | Write strobe for the status word |
| wr_data | input | 32 | Write-one-to-clear data |
| fill_req_en | input | 1 | Enable for the fill request |
| drain_req_en | input | 1 | Enable for the drain request |
| status | output | 32 | Status word |
| running | output | 1 | Transfer-running bit |
| fill_req | output | 1 | Registered fill request |
| drain_req | output | 1 | Registered drain request |

## Verification
The assertions assume that the strobes are single-cycle pulses sampled at the rising edge. They also assume that the level inputs describe a FIFO that is consistent with itself, so `tx_full` and `tx_empty` are never both high. No rule limits how `tx_push` and `tx_pop` combine at the counter limits; those cases are covered by the saturation rules. The stimulus changes inputs only at falling edges and keeps each strobe high for one cycle. It holds the FIFO levels at their idle values (TX full, RX empty) except where a test exercises the fill or drain flags.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int STAT_W = 32;
  localparam int NFLAG  = 5;

  // flag slots
  localparam int F_EOQ   = 0;
  localparam int F_UFL   = 1;
  localparam int F_FILL  = 2;
  localparam int F_OFL   = 3;
  localparam int F_DRAIN = 4;

  // vector index of each flag in the status word (index 31 is the MSB)
  localparam int FLAG_POS [NFLAG] = '{28, 27, 25, 19, 17};
  // lowest vector index of the TX counter field
  localparam int POS_CNT_LO = 12;
endpackage

// File: rtl/spi_stat_flag.sv
module spi_stat_flag (
  input  logic clk,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;
  logic q_en;

  always_comb begin
    q_en = set_i | clr_i;
    q_d  = set_i;          // set wins; otherwise the clear drives zero
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)   q_o <= 1'b0;
    else if (q_en) q_o <= q_d;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_ni)
    set_i |=> q_o); // R7
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o); // R7
endmodule

// File: rtl/spi_stat_txcnt.sv
module spi_stat_txcnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_o;
    cnt_en = 1'b0;
    if (push_i && !pop_i && cnt_o != CNT_MAX) begin
      cnt_d  = cnt_o + 1'b1;
      cnt_en = 1'b1;
    end else if (pop_i && !push_i && cnt_o != '0) begin
      cnt_d  = cnt_o - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (cnt_en) cnt_o <= cnt_d;
  end

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_ni)
    (cnt_o == CNT_MAX && push_i && !pop_i) |=> cnt_o == CNT_MAX); // R8
  AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_ni)
    (cnt_o == '0 && pop_i && !push_i) |=> cnt_o == '0); // R8
  AST_CNT_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (push_i && pop_i) |=> $stable(cnt_o)); // R8
endmodule

// File: rtl/spi_stat_flags.sv
module spi_stat_flags
  import spi_stat_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_mode,
  input  logic              run_go,
  input  logic              run_halt,
  input  logic              eoq_done,
  input  logic              xfer_start,
  input  logic              tx_push,
  input  logic              tx_pop,
  input  logic              tx_full,
  input  logic              tx_empty,
  input  logic              rx_full,
  input  logic              rx_shift_full,
  input  logic              rx_empty,
  input  logic              dma_tx_ack,
  input  logic              dma_rx_ack,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  input  logic              fill_req_en,
  input  logic              drain_req_en,
  output logic [STAT_W-1:0] status,
  output logic              running,
  output logic              fill_req,
  output logic              drain_req
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  // flag set and clear terms
  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] flag_clr;
  logic [NFLAG-1:0] flag_q;

  always_comb begin
    flag_set          = '0;
    flag_set[F_EOQ]   = eoq_done & ~slave_mode;
    flag_set[F_UFL]   = xfer_start & slave_mode & tx_empty;
    flag_set[F_FILL]  = ~tx_full;
    flag_set[F_OFL]   = xfer_start & rx_full & rx_shift_full;
    flag_set[F_DRAIN] = ~rx_empty;
    for (int i = 0; i < NFLAG; i++) begin
      flag_clr[i] = wr_en & wr_data[FLAG_POS[i]];
    end
    flag_clr[F_FILL]  = flag_clr[F_FILL]  | (dma_tx_ack & tx_full);
    flag_clr[F_DRAIN] = flag_clr[F_DRAIN] | (dma_rx_ack & rx_empty);
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    spi_stat_flag flag_i (
      .clk    (clk),
      .rst_ni (rst_q),
      .set_i  (flag_set[g]),
      .clr_i  (flag_clr[g]),
      .q_o    (flag_q[g])
    );
  end

  // TX entry counter
  logic [CNT_W-1:0] tx_cnt;

  spi_stat_txcnt #(.CNT_W(CNT_W)) txcnt_i (
    .clk    (clk),
    .rst_ni (rst_q),
    .push_i (tx_push),
    .pop_i  (tx_pop),
    .cnt_o  (tx_cnt)
  );

  // running bit
  logic run_d;
  logic run_en;

  always_comb begin
    run_en = flag_set[F_EOQ] | run_go | run_halt;
    if (flag_set[F_EOQ]) run_d = 1'b0;
    else if (run_go)     run_d = 1'b1;
    else                 run_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      running <= 1'b0;
    else if (run_en) running <= run_d;
  end

  // registered requests
  logic fill_req_d;
  logic drain_req_d;

  always_comb begin
    fill_req_d  = flag_q[F_FILL]  & fill_req_en;
    drain_req_d = flag_q[F_DRAIN] & drain_req_en;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      fill_req  <= 1'b0;
      drain_req <= 1'b0;
    end else begin
      fill_req  <= fill_req_d;
      drain_req <= drain_req_d;
    end
  end

  // status word
  always_comb begin
    status = '0;
    for (int i = 0; i < NFLAG; i++) begin
      status[FLAG_POS[i]] = flag_q[i];
    end
    status[POS_CNT_LO +: CNT_W] = tx_cnt;
  end

  AST_EOQ_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_q)
    (slave_mode && !flag_q[F_EOQ]) |=> !flag_q[F_EOQ]); // R1
  AST_EOQ_HALTS_RUN: assert property (@(posedge clk) disable iff (!rst_q)
    (eoq_done && !slave_mode) |=> !running); // R2
  AST_UFL_MASTER_QUIET: assert property (@(posedge clk) disable iff (!rst_q)
    (!slave_mode && !flag_q[F_UFL]) |=> !flag_q[F_UFL]); // R3
  AST_OFL_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_q)
    (!rx_shift_full && !flag_q[F_OFL]) |=> !flag_q[F_OFL]); // R4
  AST_FILL_LEVEL: assert property (@(posedge clk) disable iff (!rst_q)
    !tx_full |=> flag_q[F_FILL]); // R5
  AST_DRAIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_q)
    !rx_empty |=> flag_q[F_DRAIN]); // R6
  AST_FILL_NO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_q)
    (!wr_en && !dma_tx_ack && flag_q[F_FILL]) |=> flag_q[F_FILL]); // R7
  AST_FILL_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_q)
    !fill_req_en |=> !fill_req); // R9
  AST_DRAIN_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_q)
    !drain_req_en |=> !drain_req); // R9
endmodule

// File: tb/spi_stat_flags_tb_top.sv
module spi_stat_flags_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        slave_mode, run_go, run_halt, eoq_done, xfer_start;
  logic        tx_push, tx_pop, tx_full, tx_empty;
  logic        rx_full, rx_shift_full, rx_empty;
  logic        dma_tx_ack, dma_rx_ack, wr_en;
  logic [31:0] wr_data;
  logic        fill_req_en, drain_req_en;
  logic [31:0] status;
  logic        running, fill_req, drain_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_stat_flags dut_i (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .run_go(run_go),
    .run_halt(run_halt), .eoq_done(eoq_done), .xfer_start(xfer_start),
    .tx_push(tx_push), .tx_pop(tx_pop), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_full(rx_full), .rx_shift_full(rx_shift_full), .rx_empty(rx_empty),
    .dma_tx_ack(dma_tx_ack), .dma_rx_ack(dma_rx_ack), .wr_en(wr_en),
    .wr_data(wr_data), .fill_req_en(fill_req_en), .drain_req_en(drain_req_en),
    .status(status), .running(running), .fill_req(fill_req), .drain_req(drain_req)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] st;
    logic        run;
    logic        freq;
    logic        dreq;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  // bench reference state, from the requirements
  logic       m_eoq, m_ufl, m_fill, m_ofl, m_drain, m_run, m_freq, m_dreq;
  int         m_cnt;

  function automatic logic [31:0] model_word();
    logic [31:0] w = '0;
    w[28] = m_eoq; w[27] = m_ufl; w[25] = m_fill; w[19] = m_ofl; w[17] = m_drain;
    w[15:12] = m_cnt[3:0];
    return w;
  endfunction

  task automatic compare(string tag, logic [31:0] st, logic run, logic fr, logic dr,
                         logic [31:0] est, logic erun, logic efr, logic edr);
    checks++;
    if (st !== est || run !== erun || fr !== efr || dr !== edr) begin
      errors++;
      $display("FAIL %s: status=%h run=%b freq=%b dreq=%b expected status=%h run=%b freq=%b dreq=%b",
               tag, st, run, fr, dr, est, erun, efr, edr);
    end
  endtask

  // driver: apply the current inputs for one cycle and queue the expected result
  task automatic cycle(string tag);
    logic ev_eoq, ev_ufl, ev_fill, ev_ofl, ev_drain;
    logic c_eoq, c_ufl, c_fill, c_ofl, c_drain;
    exp_t e;
    ev_eoq   = eoq_done & ~slave_mode;
    ev_ufl   = xfer_start & slave_mode & tx_empty;
    ev_fill  = ~tx_full;
    ev_ofl   = xfer_start & rx_full & rx_shift_full;
    ev_drain = ~rx_empty;
    c_eoq    = wr_en & wr_data[28];
    c_ufl    = wr_en & wr_data[27];
    c_fill   = (wr_en & wr_data[25]) | (dma_tx_ack & tx_full);
    c_ofl    = wr_en & wr_data[19];
    c_drain  = (wr_en & wr_data[17]) | (dma_rx_ack & rx_empty);
    m_freq   = m_fill & fill_req_en;
    m_dreq   = m_drain & drain_req_en;
    m_eoq    = ev_eoq   ? 1'b1 : (c_eoq   ? 1'b0 : m_eoq);
    m_ufl    = ev_ufl   ? 1'b1 : (c_ufl   ? 1'b0 : m_ufl);
    m_fill   = ev_fill  ? 1'b1 : (c_fill  ? 1'b0 : m_fill);
    m_ofl    = ev_ofl   ? 1'b1 : (c_ofl   ? 1'b0 : m_ofl);
    m_drain  = ev_drain ? 1'b1 : (c_drain ? 1'b0 : m_drain);
    if (ev_eoq)        m_run = 1'b0;
    else if (run_go)   m_run = 1'b1;
    else if (run_halt) m_run = 1'b0;
    if (tx_push && !tx_pop && m_cnt < 15)      m_cnt++;
    else if (tx_pop && !tx_push && m_cnt > 0)  m_cnt--;
    e.st = model_word(); e.run = m_run; e.freq = m_freq; e.dreq = m_dreq; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    run_go = 0; run_halt = 0; eoq_done = 0; xfer_start = 0; tx_push = 0; tx_pop = 0;
    dma_tx_ack = 0; dma_rx_ack = 0; wr_en = 0; wr_data = '0;
  endtask

  // monitor: compare one result per edge while expectations are queued
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      compare(e.tag, status, running, fill_req, drain_req, e.st, e.run, e.freq, e.dreq);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; slave_mode = 0; run_go = 0; run_halt = 0; eoq_done = 0; xfer_start = 0;
    tx_push = 0; tx_pop = 0; tx_full = 1; tx_empty = 0; rx_full = 0; rx_shift_full = 0;
    rx_empty = 1; dma_tx_ack = 0; dma_rx_ack = 0; wr_en = 0; wr_data = '0;
    fill_req_en = 0; drain_req_en = 0;
    m_eoq = 0; m_ufl = 0; m_fill = 0; m_ofl = 0; m_drain = 0; m_run = 0;
    m_freq = 0; m_dreq = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    compare("R11 reset held", status, running, fill_req, drain_req, '0, 0, 0, 0);
    rst_n = 1;
    tx_full = 0;                       // would set fill if not held in reset
    @(negedge clk);
    compare("R11 first edge after release", status, running, fill_req, drain_req, '0, 0, 0, 0);
    tx_full = 1;
    @(negedge clk);
    @(negedge clk);

    // R8 counter
    for (int i = 0; i < 3; i++) begin tx_push = 1; cycle("R8 push"); end
    tx_push = 1; tx_pop = 1; cycle("R8 push and pop hold");
    for (int i = 0; i < 14; i++) begin tx_push = 1; cycle("R8 push to saturation"); end
    tx_pop = 1; cycle("R8 pop from full");
    for (int i = 0; i < 16; i++) begin tx_pop = 1; cycle("R8 pop to floor"); end

    // R5 fill flag and R9 fill request
    fill_req_en = 1;
    tx_full = 0; cycle("R5 fill sets while not full");
    wr_en = 1; wr_data[25] = 1; cycle("R7 set beats write-one clear");
    tx_full = 1; cycle("R5 fill kept after full, R9 request");
    wr_en = 1; wr_data = 32'hFDFF_FFFF; cycle("R7 write zero keeps fill");
    wr_en = 1; wr_data[25] = 1; cycle("R5 write one clears fill");
    cycle("R9 fill request drops");
    tx_full = 0; cycle("R5 fill sets again");
    tx_full = 1; dma_tx_ack = 1; cycle("R5 dma ack clears fill when full");
    tx_full = 0; fill_req_en = 0; cycle("R9 request gated by enable");
    tx_full = 1; cycle("R9 gated hold");
    dma_tx_ack = 1; cycle("R5 dma clear"); fill_req_en = 0;

    // R6 drain flag and R9 drain request
    drain_req_en = 1;
    rx_empty = 0; cycle("R6 drain sets while not empty");
    rx_empty = 1; cycle("R6 drain kept, R9 request");
    dma_rx_ack = 1; cycle("R6 dma ack clears drain");
    rx_empty = 0; cycle("R6 drain sets again");
    rx_empty = 1; wr_en = 1; wr_data[17] = 1; cycle("R6 write one clears drain");
    cycle("R9 drain request drops");

    // R1 and R2 end of queue with running bit
    run_go = 1; cycle("R2 run_go sets running");
    eoq_done = 1; cycle("R1 eoq sets, R2 running cleared");
    run_go = 1; eoq_done = 1; cycle("R2 eoq beats run_go");
    wr_en = 1; wr_data[28] = 1; cycle("R1 write one clears eoq");
    run_go = 1; cycle("R2 run again");
    run_halt = 1; cycle("R2 run_halt clears running");
    slave_mode = 1; run_go = 1; cycle("R2 slave run");
    eoq_done = 1; cycle("R1 no eoq in slave mode");

    // R3 underflow
    tx_full = 0; tx_empty = 1; xfer_start = 1; cycle("R3 underflow in slave");
    wr_en = 1; wr_data[27] = 1; cycle("R3 write one clears underflow");
    slave_mode = 0; xfer_start = 1; cycle("R3 no underflow in master");
    tx_empty = 0; tx_full = 1; wr_en = 1; wr_data[25] = 1; cycle("R5 clear fill");

    // R4 overflow
    rx_full = 1; xfer_start = 1; cycle("R4 no overflow without shift full");
    rx_shift_full = 1; xfer_start = 1; cycle("R4 overflow sets");
    cycle("R4 overflow sticky");
    wr_en = 1; wr_data = 32'h0008_0000; cycle("R4 write one clears overflow");

    // R10 reserved bits under all-ones write
    tx_push = 1; cycle("R10 counter visible");
    wr_en = 1; wr_data = '1; cycle("R10 reserved stay zero");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule